// File: doc/BRIEF.md
# Quad-Lane Serial RAM Frame Streamer

This block treats four quad-SPI serial RAM chips as one 16-bit-wide frame memory. The four chips share a serial clock and a chip select. Each chip owns one 4-bit lane of a 16-bit bus: lane k is bits 4k+3..4k. Every chip must receive the same command and address. Each header nibble is therefore copied onto all four lanes, so a nibble value n appears on the bus as n × 16'h1111.

A host starts a transfer by raising a request. With it the host gives a direction, a scan-line number and a length. The line number selects a 256-location line: the column bits of the device address are sent as zero. After a short header, data streams one 16-bit word per serial clock, with no further addressing, until the requested count is reached or the host withdraws its request. The serial clock is paced in hardware. It pauses when the write source runs dry or when the read sink is not ready, so neither underrun nor overrun is possible.

Top module: `qspi_array_streamer`

## Requirements
- R1: After reset, cs_no is 1, sck_o is 0, dq_oe_o is 0, rvalid_o is 0, wready_o is 0 and busy_o is 0.
- R2: A transfer starts only on a 0-to-1 change of req_i while idle. Holding req_i at 1 after a transfer has finished starts no new transfer.
- R3: The header starts with an 8-bit command, high nibble first: 0x0B when we_i is 0 (read) and 0x02 when we_i is 1 (write). Every chip receives the same command.
- R4: The command is followed by a 24-bit address sent as six nibbles, most significant first. Its value is line_i × 256, so the column bits are zero. During the header every lane carries the same nibble.
- R5: One serial clock lasts at least two clk_i cycles. dq_o never changes on the clk_i edge that raises sck_o.
- R6: A read sends 8 dummy clocks with dq_oe_o at 0, then captures one word from dq_i per serial clock. It gives 16 + N rising edges of sck_o in total.
- R7: A write drives each accepted wdata_i word on dq_o for one serial clock, and the chip on lane k stores bits 4k+3..4k. A write gives 8 + N rising edges of sck_o.
- R8: The word count N of a transfer is len_i + 1. Words fill consecutive locations from the line start, and are returned or stored in order.
- R9: While a write is waiting for a word (wready_o is 1 and wvalid_i is 0), sck_o stays high and no rising edge occurs.
- R10: While rvalid_o is 1 and rready_i is 0, rdata_o and rvalid_o hold and no new word is captured.
- R11: If req_i falls during a transfer, cs_no is 1 and busy_o is 0 one cycle later. The words delivered up to then are the correct leading words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request; a rising edge starts a transfer, and a fall aborts it |
| we_i | input | 1 | 1 = write, 0 = read; sampled at start |
| line_i | input | 8 | Scan line; the address is line × 256 |
| len_i | input | 8 | Word count minus one |
| busy_o | output | 1 | A transfer is in progress |
| wdata_i | input | 16 | Write word |
| wvalid_i | input | 1 | Write word valid |
| wready_o | output | 1 | Write word accepted on this edge if valid |
| rdata_o | output | 16 | Read word |
| rvalid_o | output | 1 | Read word valid |
| rready_i | input | 1 | Read sink ready |
| sck_o | output | 1 | Shared serial clock |
| cs_no | output | 1 | Shared chip select, active low |
| dq_o | output | 16 | Lane data out, four chips × 4 bits |
| dq_oe_o | output | 1 | Lane output enable |
| dq_i | input | 16 | Lane data in |

## Verification
The bench drives inputs and samples outputs on the falling clk_i edge. A write word is taken on the rising edge after the falling edge at which wvalid_i and wready_o are both seen high. A read word counts as delivered when rvalid_o and rready_i are both high at the same falling edge. Header and data timing are checked through counts of sck_o rising edges (16 + N for a read, 8 + N for a write) and through the command and address that each lane model collects. An abort is checked at the very next falling edge, where cs_no must already be high.

// File: rtl/qsa_pkg.sv
package qsa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_HDR, ST_DUMMY, ST_DATA
  } qsa_state_e;

  localparam logic [7:0] CMD_RD = 8'h0B;
  localparam logic [7:0] CMD_WR = 8'h02;
endpackage

// File: rtl/qsa_hdr.sv
module qsa_hdr import qsa_pkg::*; #(
  parameter int LANES  = 4,
  parameter int LINE_W = 8,
  parameter int COL_W  = 8,
  parameter int ADDR_W = 24,
  parameter int HDR_N  = 8,
  parameter int IDX_W  = 3
) (
  input  logic                 we_i,
  input  logic [LINE_W-1:0]    line_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [4*LANES-1:0]   bus_o
);
  localparam int HDR_W = 8 + ADDR_W;

  logic [ADDR_W-1:0] addr;
  logic [HDR_W-1:0]  hdr;
  logic [3:0]        nib;

  always_comb begin
    addr = ADDR_W'(line_i) << COL_W;
    hdr  = {(we_i ? CMD_WR : CMD_RD), addr};
    nib  = 4'(hdr >> (4 * (HDR_N - 1 - int'(idx_i))));
  end

  // same nibble on every lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bus_o[4*g +: 4] = nib;
  end
endmodule

// File: rtl/qsa_ctrl.sv
module qsa_ctrl import qsa_pkg::*; #(
  parameter int DATA_W  = 16,
  parameter int LEN_W   = 8,
  parameter int LINE_W  = 8,
  parameter int HDR_N   = 8,
  parameter int DUMMY_N = 8,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              busy_o,
  output logic              we_o,
  output logic [LINE_W-1:0] line_o,
  output logic [IDX_W-1:0]  hdr_idx_o,
  input  logic [DATA_W-1:0] hdr_bus_i,
  output qsa_state_e        st_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic              sck_o,
  output logic              cs_no,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i
);
  localparam int WC_W = LEN_W + 1;

  qsa_state_e        st_q;
  logic              req_d, ph_q, we_q, cs_n_q, oe_q, rvalid_q;
  logic [LINE_W-1:0] line_q;
  logic [LEN_W-1:0]  len_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WC_W-1:0]   wcnt_q, total;
  logic [DATA_W-1:0] dq_q, rdata_q;
  logic              start, last, hdr_end;

  assign total   = WC_W'(len_q) + WC_W'(1);
  assign last    = (wcnt_q == total);
  assign start   = req_i && !req_d;
  assign hdr_end = (cnt_q == CNT_W'(HDR_N - 1));

  assign hdr_idx_o = (st_q == ST_HDR) ? IDX_W'(cnt_q + CNT_W'(1)) : '0;
  assign wready_o  = req_i && ph_q && we_q &&
                     ((st_q == ST_HDR && hdr_end) || (st_q == ST_DATA && !last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; req_d <= 1'b0; ph_q <= 1'b0; we_q <= 1'b0;
      cs_n_q <= 1'b1; oe_q <= 1'b0; rvalid_q <= 1'b0; line_q <= '0;
      len_q <= '0; cnt_q <= '0; wcnt_q <= '0; dq_q <= '0; rdata_q <= '0;
    end else begin
      req_d <= req_i;
      if (rvalid_q && rready_i) rvalid_q <= 1'b0;
      if (st_q != ST_IDLE && !req_i) begin
        st_q <= ST_IDLE; cs_n_q <= 1'b1; oe_q <= 1'b0; ph_q <= 1'b0;
      end else begin
        case (st_q)
          ST_IDLE: if (start) begin
            we_q <= we_i; line_q <= line_i; len_q <= len_i;
            cs_n_q <= 1'b0; st_q <= ST_SETUP;
          end
          ST_SETUP: begin
            dq_q <= hdr_bus_i; oe_q <= 1'b1; cnt_q <= '0;
            wcnt_q <= '0; ph_q <= 1'b0; st_q <= ST_HDR;
          end
          ST_HDR: if (!ph_q) ph_q <= 1'b1;
            else if (!hdr_end) begin
              dq_q <= hdr_bus_i; cnt_q <= cnt_q + CNT_W'(1); ph_q <= 1'b0;
            end else if (!we_q) begin
              oe_q <= 1'b0; cnt_q <= '0; ph_q <= 1'b0; st_q <= ST_DUMMY;
            end else if (wvalid_i) begin
              dq_q <= wdata_i; wcnt_q <= wcnt_q + WC_W'(1);
              ph_q <= 1'b0; st_q <= ST_DATA;
            end
          ST_DUMMY: if (!ph_q) ph_q <= 1'b1;
            else begin
              ph_q <= 1'b0;
              if (cnt_q == CNT_W'(DUMMY_N - 1)) st_q <= ST_DATA;
              else cnt_q <= cnt_q + CNT_W'(1);
            end
          ST_DATA: if (!ph_q) begin
              if (we_q) ph_q <= 1'b1;
              else if (!(rvalid_q && !rready_i)) begin
                // capture on the edge that raises sck
                ph_q <= 1'b1; rdata_q <= dq_i; rvalid_q <= 1'b1;
                wcnt_q <= wcnt_q + WC_W'(1);
              end
            end else if (last) begin
              st_q <= ST_IDLE; cs_n_q <= 1'b1; oe_q <= 1'b0; ph_q <= 1'b0;
            end else if (!we_q) ph_q <= 1'b0;
            else if (wvalid_i) begin
              dq_q <= wdata_i; wcnt_q <= wcnt_q + WC_W'(1); ph_q <= 1'b0;
            end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign we_o     = we_q;
  assign line_o   = line_q;
  assign st_o     = st_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign sck_o    = ph_q;
  assign cs_no    = cs_n_q;
  assign dq_o     = dq_q;
  assign dq_oe_o  = oe_q;
endmodule

// File: rtl/qspi_array_streamer.sv
module qspi_array_streamer import qsa_pkg::*; #(
  parameter int LANES   = 4,
  parameter int LINE_W  = 8,
  parameter int COL_W   = 8,
  parameter int ADDR_W  = 24,
  parameter int LEN_W   = 8,
  parameter int DUMMY_N = 8,
  localparam int DATA_W = 4 * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              busy_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic              sck_o,
  output logic              cs_no,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i
);
  localparam int HDR_N = (8 + ADDR_W) / 4;
  localparam int IDX_W = $clog2(HDR_N);
  localparam int CNT_MAX = (HDR_N > DUMMY_N) ? HDR_N : DUMMY_N;
  localparam int CNT_W = $clog2(CNT_MAX);

  logic              we_w;
  logic [LINE_W-1:0] line_w;
  logic [IDX_W-1:0]  idx_w;
  logic [DATA_W-1:0] hdr_bus;
  qsa_state_e        st_w;
  logic              in_hdr;

  assign in_hdr = (st_w == ST_HDR);

  qsa_hdr #(
    .LANES(LANES), .LINE_W(LINE_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
    .HDR_N(HDR_N), .IDX_W(IDX_W)
  ) u_hdr (
    .we_i(we_w), .line_i(line_w), .idx_i(idx_w), .bus_o(hdr_bus)
  );

  qsa_ctrl #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .LINE_W(LINE_W), .HDR_N(HDR_N),
    .DUMMY_N(DUMMY_N), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_i, .we_i, .line_i, .len_i, .busy_o,
    .we_o(we_w), .line_o(line_w), .hdr_idx_o(idx_w), .hdr_bus_i(hdr_bus),
    .st_o(st_w), .wdata_i, .wvalid_i, .wready_o, .rdata_o, .rvalid_o,
    .rready_i, .sck_o, .cs_no, .dq_o, .dq_oe_o, .dq_i
  );
endmodule

// File: rtl/qsa_chk.sv
module qsa_chk #(
  parameter int LANES = 4,
  localparam int DATA_W = 4 * LANES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              busy_o,
  input logic              cs_no,
  input logic              sck_o,
  input logic              dq_oe_o,
  input logic [DATA_W-1:0] dq_o,
  input logic              wready_o,
  input logic              wvalid_i,
  input logic              rvalid_o,
  input logic              rready_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              hdr_phase_i
);
  // R1
  idle_bus_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (!sck_o && !dq_oe_o));

  // R4
  hdr_lanes_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_phase_i |-> (dq_o == {LANES{dq_o[3:0]}}));

  // R5
  dq_hold_at_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> $stable(dq_o));

  // R9
  wr_stall_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wready_o && !wvalid_i) |=> sck_o);

  // R10
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !rready_i) |=> (rvalid_o && $stable(rdata_o)));

  // R11
  abort_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !req_i) |=> (cs_no && !busy_o));
endmodule

bind qspi_array_streamer qsa_chk #(.LANES(LANES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .busy_o(busy_o),
  .cs_no(cs_no), .sck_o(sck_o), .dq_oe_o(dq_oe_o), .dq_o(dq_o),
  .wready_o(wready_o), .wvalid_i(wvalid_i), .rvalid_o(rvalid_o),
  .rready_i(rready_i), .rdata_o(rdata_o), .hdr_phase_i(in_hdr)
);

// File: tb/qspi_array_streamer_bench.sv
package qsa_tb_pkg;
  function automatic logic [3:0] lane_pat(int a, int lane);
    return 4'((a ^ (a >> 4) ^ (a >> 9)) + lane * 5);
  endfunction
endpackage

module qsa_lane_model import qsa_tb_pkg::*; #(parameter int LANE = 0) (
  input  logic        sck_i,
  input  logic        cs_ni,
  input  logic [3:0]  din_i,
  output logic [3:0]  dout_o,
  output logic [7:0]  cmd_o,
  output logic [23:0] addr_o
);
  logic [3:0] mem [int];
  int edges = 0;
  logic [7:0]  cmd = '0;
  logic [23:0] addr = '0;

  always @(posedge sck_i or posedge cs_ni) begin
    if (cs_ni) edges <= 0;
    else begin
      edges <= edges + 1;
      if (edges < 2) cmd <= {cmd[3:0], din_i};
      else if (edges < 8) addr <= {addr[19:0], din_i};
      else if (cmd == 8'h02) mem[int'(addr) + edges - 8] = din_i;
    end
  end

  always @(negedge sck_i) begin
    if (!cs_ni && cmd == 8'h0B && edges >= 16) begin
      if (mem.exists(int'(addr) + edges - 16)) dout_o <= mem[int'(addr) + edges - 16];
      else dout_o <= lane_pat(int'(addr) + edges - 16, LANE);
    end
  end

  assign cmd_o  = cmd;
  assign addr_o = addr;
endmodule

module qspi_array_streamer_bench import qsa_tb_pkg::*;;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we_in = 1'b0, wvalid = 1'b0, rready = 1'b0;
  logic [7:0]  line_in = '0, len_in = '0;
  logic [15:0] wdata = '0;
  logic        busy_o, wready_o, rvalid_o, sck_o, cs_no, dq_oe_o;
  logic [15:0] rdata_o, dq_o, dq_i;
  logic [7:0]  lane_cmd [4];
  logic [23:0] lane_addr [4];
  logic [15:0] shadow [int];
  int checks = 0, errors = 0, cycles = 0;
  logic [15:0] wseed = 16'h5A00;

  always #4 clk = ~clk;

  qspi_array_streamer u_qspi_array_streamer (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we_in), .line_i(line_in),
    .len_i(len_in), .busy_o(busy_o), .wdata_i(wdata), .wvalid_i(wvalid),
    .wready_o(wready_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .rready_i(rready), .sck_o(sck_o), .cs_no(cs_no), .dq_o(dq_o),
    .dq_oe_o(dq_oe_o), .dq_i(dq_i)
  );

  for (genvar k = 0; k < 4; k++) begin : g_dev
    qsa_lane_model #(.LANE(k)) u_dev (
      .sck_i(sck_o), .cs_ni(cs_no), .din_i(dq_o[4*k +: 4]),
      .dout_o(dq_i[4*k +: 4]), .cmd_o(lane_cmd[k]), .addr_o(lane_addr[k])
    );
  end

  task automatic chk(input bit ok, input string req_s, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_s, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(int a);
    if (shadow.exists(a)) return shadow[a];
    return {lane_pat(a, 3), lane_pat(a, 2), lane_pat(a, 1), lane_pat(a, 0)};
  endfunction

  function automatic logic [15:0] wval(logic [7:0] line, int j);
    return 16'(line * 16'h0101) ^ 16'(j * 16'h03B1) ^ wseed;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic txn(input bit we, input logic [7:0] line, input logic [7:0] len,
                     input int wgap, input int rgap, input int abort_at);
    int n = int'(len) + 1;
    int got = 0, sent = 0, rises = 0, cyc = 0;
    bit prev_sck = 1'b0, seen = 1'b0, aborted = 1'b0, pend = 1'b0;
    int base = int'(line) * 256;
    @(negedge clk);
    we_in = we; line_in = line; len_in = len; req = 1'b1;
    do begin
      @(negedge clk);
      cyc++;
      if (pend) begin
        // R11 abort lands one cycle after req falls
        chk(cs_no && !busy_o, "R11 abort cs", {cs_no, busy_o}, 2'b10);
        pend = 1'b0;
      end
      if (busy_o) seen = 1'b1;
      if (sck_o && !prev_sck) rises++;
      prev_sck = sck_o;
      rready = ((cyc % (rgap + 1)) == 0);
      if (rvalid_o && rready) begin
        // R8 order, R10 backpressure
        chk(rdata_o == exp_word(base + got), "R8 read word", rdata_o, exp_word(base + got));
        got++;
      end
      wvalid = we && sent < n && ((cyc % (wgap + 1)) == 0);
      wdata = wval(line, sent);
      if (wvalid && wready_o) begin
        shadow[base + sent] = wdata;
        sent++;
      end
      if (abort_at >= 0 && !aborted && got >= abort_at) begin
        req = 1'b0; aborted = 1'b1; pend = 1'b1;
      end
    end while (!seen || busy_o || rvalid_o || pend);
    wvalid = 1'b0; rready = 1'b0;
    if (aborted) begin
      chk(got >= abort_at && got < n, "R11 partial count", got, abort_at);
      return;
    end
    for (int k = 0; k < 4; k++) begin
      chk(lane_cmd[k] == (we ? 8'h02 : 8'h0B), "R3 command", lane_cmd[k], we ? 8'h02 : 8'h0B);
      chk(lane_addr[k] == 24'(base), "R4 address", lane_addr[k], base);
    end
    if (we) begin
      // R7 R9 rise count holds under stalls
      chk(rises == 8 + n, "R7 write rises", rises, 8 + n);
      chk(sent == n, "R8 write count", sent, n);
    end else begin
      // R6 R5 read rise count
      chk(rises == 16 + n, "R6 read rises", rises, 16 + n);
      chk(got == n, "R8 read count", got, n);
    end
    // R2 holding req high does not restart
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (!cs_no || busy_o) quiet = 1'b0;
      end
      chk(quiet, "R2 no restart", quiet, 1);
    end
    req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_no && !sck_o && !dq_oe_o && !rvalid_o && !busy_o && !wready_o, "R1 reset",
        {cs_no, sck_o, dq_oe_o, rvalid_o, busy_o, wready_o}, 6'b100000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_no && !busy_o, "R1 idle after reset", {cs_no, busy_o}, 2'b10);

    for (int l = 0; l < 16; l++) txn(1'b0, 8'(l * 17), 8'(l * 17), 0, 0, -1);

    txn(1'b1, 8'h3C, 8'd255, 0, 0, -1);
    txn(1'b1, 8'h3D, 8'd40, 1, 0, -1);
    txn(1'b1, 8'h3E, 8'd9, 2, 0, -1);
    txn(1'b1, 8'hC3, 8'd0, 3, 0, -1);
    txn(1'b0, 8'h3C, 8'd255, 0, 1, -1);
    txn(1'b0, 8'h3D, 8'd40, 0, 2, -1);
    txn(1'b0, 8'h3E, 8'd9, 0, 3, -1);
    txn(1'b0, 8'hC3, 8'd0, 0, 0, -1);

    wseed = 16'h0F0F;
    txn(1'b1, 8'h3C, 8'd3, 1, 0, -1);
    txn(1'b0, 8'h3C, 8'd7, 0, 1, -1);

    txn(1'b0, 8'h77, 8'd255, 0, 0, 5);
    txn(1'b0, 8'h77, 8'd3, 0, 0, -1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule